// File: doc/BRIEF.md
# Receive Sample Format Packer

This block sits between a receive signal path and a host link buffer. Each input sample is a complex pair: a signed 16-bit I component and a signed 16-bit Q component, offered together on a valid/ready handshake. The block turns these samples into a stream of 16-bit words on a second valid/ready handshake. A 32-bit format word chooses how that stream is formed. It sets an arithmetic right shift, the width of each delivered component, and whether Q is sent along with I. It also carries a filter-bypass flag. The block does not act on that flag; it only presents it on a status output.

Each component is shifted and then cut down to the chosen width. The low bits are kept, with no rounding and no saturation. The components are then packed into words with I ahead of Q. At 16 bits, each component takes a whole word. At 8 bits, two components share a word and the earlier one sits in the low byte.

The format word is checked when it is written. A bad write changes nothing in the format and sets a sticky error flag. A good write is held as pending. It takes over only when no word is half built and no second word of a sample is still waiting. This way a single word never mixes two formats.

Top module: `rx_fmt_packer`

## Requirements
- R1: After reset, out_valid and cfg_err are 0, bypass is 0, in_ready is 1, and the format in force is 0x00000300 (width 16, shift 0, I and Q delivered).
- R2: With width 16, shift 0 and Q delivery on, each sample yields two words: first the I component, then the Q component, both unchanged.
- R3: With bit 9 of the format clear at width 16, each sample yields one word holding its I component, and Q is dropped.
- R4: With width 8, shift 8 and Q delivery on, each sample yields one word. Its low byte is bits [7:0] of I arithmetically shifted right by 8, and its high byte is the same for Q.
- R5: With width 8 and Q delivery off, the narrowed I values of two consecutive samples form one word, the first sample in the low byte.
- R6: In the format word, bits [3:0] are the shift, bits [8:4] the component width, bit 9 enables Q delivery and bit 10 is the bypass flag. The bypass output shows bit 10 of the format in force.
- R7: A write with a nonzero bit in [31:11], or with a width/shift pair other than 16/0 or 8/8, sets cfg_err on the next cycle. cfg_err then stays 1 until reset, and the format in force does not change.
- R8: A valid format written while a word is half built takes effect only after that word is finished in the old format.
- R9: While out_valid is 1 and out_ready is 0, out_data holds steady and in_ready is 0. No sample or word is lost or repeated under backpressure.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Write strobe for the format word |
| cfg_data | input | 32 | Format word to write |
| in_valid | input | 1 | Input sample offered |
| in_ready | output | 1 | Input sample accepted this cycle when in_valid is 1 |
| in_i | input | 16 | Signed I component |
| in_q | input | 16 | Signed Q component |
| out_valid | output | 1 | Output word available |
| out_ready | input | 1 | Downstream takes the word |
| out_data | output | 16 | Packed output word |
| cfg_err | output | 1 | Sticky flag for a rejected format write |
| bypass | output | 1 | Filter-bypass flag of the format in force |

## Verification
A sample accepted at a clock edge shows up in out_data from the next edge onward. A second Q word at width 16 follows only once the first word has been taken. A rejected write raises cfg_err one edge after the strobe. A valid write is pending from that edge and takes over at the first word boundary after it. The bench drives its inputs just after each rising edge and reads every port at the falling edge, so handshakes and flags are seen exactly one register stage after their cause. A queue model decides the format of each accepted sample from its own copy of the pending format and the half-word state, and every output handshake is compared to the head of that queue.

// File: rtl/rx_fmt_pkg.sv
package rx_fmt_pkg;
    localparam int CFG_W   = 32;
    localparam int SAMP_W  = 16;
    localparam int WORD_W  = 16;
    localparam int SHIFT_W = 4;
    localparam int WIDTH_W = 5;
    localparam int HALF_W  = WORD_W / 2;
    localparam logic [CFG_W-1:0] CFG_RESET = 32'h0000_0300;

    typedef struct packed {
        logic               bypass;
        logic               both;
        logic [WIDTH_W-1:0] width;
        logic [SHIFT_W-1:0] shift;
    } fmt_cfg_t;

    localparam int USED_W = $bits(fmt_cfg_t);

    typedef struct packed {
        fmt_cfg_t cur;
        fmt_cfg_t pend;
        logic     pend_vld;
        logic     err;
    } cfg_state_t;

    typedef struct packed {
        logic              out_vld;
        logic [WORD_W-1:0] out_data;
        logic              hold_vld;
        logic [WORD_W-1:0] hold;
        logic              part_vld;
        logic [HALF_W-1:0] part;
    } pack_state_t;

    function automatic fmt_cfg_t cfg_fields(input logic [CFG_W-1:0] d);
        return fmt_cfg_t'(d[USED_W-1:0]);
    endfunction

    function automatic logic cfg_ok(input logic [CFG_W-1:0] d);
        fmt_cfg_t f;
        f = cfg_fields(d);
        return (d[CFG_W-1:USED_W] == '0) &&
               (((f.width == WIDTH_W'(16)) && (f.shift == SHIFT_W'(0))) ||
                ((f.width == WIDTH_W'(8))  && (f.shift == SHIFT_W'(8))));
    endfunction
endpackage

// File: rtl/rx_fmt_cfg.sv
module rx_fmt_cfg
    import rx_fmt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    input  logic             boundary,
    output fmt_cfg_t         eff,
    output logic             bypass,
    output logic             err
);
    cfg_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        eff  = (st_q.pend_vld && boundary) ? st_q.pend : st_q.cur;
        st_d.cur = eff;
        if (boundary) st_d.pend_vld = 1'b0;
        if (cfg_wr) begin
            if (cfg_ok(cfg_data)) begin
                st_d.pend     = cfg_fields(cfg_data);
                st_d.pend_vld = 1'b1;
            end else begin
                st_d.err = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.cur      <= cfg_fields(CFG_RESET);
            st_q.pend     <= cfg_fields(CFG_RESET);
            st_q.pend_vld <= 1'b0;
            st_q.err      <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bypass = st_q.cur.bypass;
    assign err    = st_q.err;

    assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);
    assert_bad_write_flags_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && !cfg_ok(cfg_data)) |=> err);
    assert_cur_supported_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.cur.width == WIDTH_W'(16)) && (st_q.cur.shift == SHIFT_W'(0))) ||
        ((st_q.cur.width == WIDTH_W'(8))  && (st_q.cur.shift == SHIFT_W'(8))));
    assert_switch_on_boundary_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !boundary |=> $stable(st_q.cur));
endmodule

// File: rtl/rx_fmt_narrow.sv
module rx_fmt_narrow
    import rx_fmt_pkg::*;
(
    input  logic [SAMP_W-1:0]  comp,
    input  logic [SHIFT_W-1:0] shift,
    input  logic [WIDTH_W-1:0] width,
    output logic [SAMP_W-1:0]  narrow
);
    logic signed [SAMP_W-1:0] shifted;
    logic [SAMP_W-1:0]        mask;

    always_comb begin
        shifted = $signed(comp) >>> shift;
        mask    = '0;
        for (int b = 0; b < SAMP_W; b++) begin
            if (b < int'(width)) mask[b] = 1'b1;
        end
        narrow = shifted & mask;
    end
endmodule

// File: rtl/rx_fmt_pack.sv
module rx_fmt_pack
    import rx_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  fmt_cfg_t          eff,
    input  logic              in_valid,
    input  logic [SAMP_W-1:0] i_n,
    input  logic [SAMP_W-1:0] q_n,
    output logic              in_ready,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_data,
    output logic              boundary
);
    pack_state_t st_q, st_d;
    logic        slot_free;
    logic        half;

    always_comb begin
        st_d      = st_q;
        slot_free = !st_q.out_vld || out_ready;
        in_ready  = slot_free && !st_q.hold_vld;
        boundary  = !st_q.hold_vld && !st_q.part_vld;
        half      = (eff.width == WIDTH_W'(HALF_W));
        if (st_q.out_vld && out_ready) st_d.out_vld = 1'b0;
        if (slot_free && st_q.hold_vld) begin
            st_d.out_vld  = 1'b1;
            st_d.out_data = st_q.hold;
            st_d.hold_vld = 1'b0;
        end else if (in_valid && in_ready) begin
            if (!half) begin
                st_d.out_vld  = 1'b1;
                st_d.out_data = WORD_W'(i_n);
                if (eff.both) begin
                    st_d.hold_vld = 1'b1;
                    st_d.hold     = WORD_W'(q_n);
                end
            end else if (eff.both) begin
                st_d.out_vld  = 1'b1;
                st_d.out_data = {q_n[HALF_W-1:0], i_n[HALF_W-1:0]};
            end else if (st_q.part_vld) begin
                st_d.out_vld  = 1'b1;
                st_d.out_data = {i_n[HALF_W-1:0], st_q.part};
                st_d.part_vld = 1'b0;
            end else begin
                st_d.part     = i_n[HALF_W-1:0];
                st_d.part_vld = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = st_q.out_vld;
    assign out_data  = st_q.out_data;

    assert_out_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
    assert_stall_blocks_input_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);
    assert_q_word_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && !half && eff.both) |=> (out_valid && st_q.hold_vld));
endmodule

// File: rtl/rx_fmt_packer.sv
module rx_fmt_packer
    import rx_fmt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_wr,
    input  logic [CFG_W-1:0]  cfg_data,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [SAMP_W-1:0] in_i,
    input  logic [SAMP_W-1:0] in_q,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [WORD_W-1:0] out_data,
    output logic              cfg_err,
    output logic              bypass
);
    localparam int NCOMP = 2;

    fmt_cfg_t          eff;
    logic              boundary;
    logic [SAMP_W-1:0] comp_raw [NCOMP];
    logic [SAMP_W-1:0] comp_nar [NCOMP];

    assign comp_raw[0] = in_i;
    assign comp_raw[1] = in_q;

    rx_fmt_cfg u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_wr   (cfg_wr),
        .cfg_data (cfg_data),
        .boundary (boundary),
        .eff      (eff),
        .bypass   (bypass),
        .err      (cfg_err)
    );

    for (genvar g = 0; g < NCOMP; g++) begin : g_comp
        rx_fmt_narrow u_narrow (
            .comp   (comp_raw[g]),
            .shift  (eff.shift),
            .width  (eff.width),
            .narrow (comp_nar[g])
        );
    end

    rx_fmt_pack u_pack (
        .clk       (clk),
        .rst_n     (rst_n),
        .eff       (eff),
        .in_valid  (in_valid),
        .i_n       (comp_nar[0]),
        .q_n       (comp_nar[1]),
        .in_ready  (in_ready),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .boundary  (boundary)
    );
endmodule

// File: tb/rx_fmt_packer_bench.sv
module rx_fmt_packer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_wr = 1'b0;
    logic [31:0] cfg_data = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [15:0] in_i = '0;
    logic [15:0] in_q = '0;
    logic        out_valid;
    logic        out_ready = 1'b1;
    logic [15:0] out_data;
    logic        cfg_err;
    logic        bypass;

    int tests = 0;
    int fails = 0;
    int cycles = 0;
    bit backpress = 1'b0;
    bit done = 1'b0;

    int m_shift = 0, m_w = 16, m_both = 1, m_byp = 0;
    bit m_pend = 0;
    logic [31:0] m_pend_val = '0;
    bit m_part = 0;
    logic [7:0] m_part_b = '0;
    bit m_err = 0;
    logic [15:0] exp_q [$];
    string cur_req = "R2";

    always #2.5 clk = ~clk;

    rx_fmt_packer u_rx_fmt_packer (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_data(cfg_data),
        .in_valid(in_valid), .in_ready(in_ready), .in_i(in_i), .in_q(in_q),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .cfg_err(cfg_err), .bypass(bypass)
    );

    function automatic logic [15:0] nar(input logic [15:0] x, input int s, input int w);
        int v;
        v = $signed(x);
        v = v >>> s;
        return (w == 16) ? v[15:0] : {8'h00, v[7:0]};
    endfunction

    function automatic bit good_cfg(input logic [31:0] d);
        int s, w;
        s = int'(d[3:0]);
        w = int'(d[8:4]);
        return (d[31:11] == 0) && ((w == 16 && s == 0) || (w == 8 && s == 8));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        out_ready <= #1 backpress ? 1'($urandom % 2) : 1'b1;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (out_valid && out_ready) begin
                if (exp_q.size() == 0) begin
                    check(cur_req, {16'h0, out_data}, 32'hDEAD_0000);
                end else begin
                    check(cur_req, {16'h0, out_data}, {16'h0, exp_q.pop_front()});
                end
            end
            if (in_valid && in_ready) begin
                if (m_pend && !m_part) begin
                    m_shift = int'(m_pend_val[3:0]);
                    m_w     = int'(m_pend_val[8:4]);
                    m_both  = int'(m_pend_val[9]);
                    m_byp   = int'(m_pend_val[10]);
                    m_pend  = 0;
                end
                if (m_w == 16) begin
                    exp_q.push_back(nar(in_i, m_shift, 16));
                    if (m_both) exp_q.push_back(nar(in_q, m_shift, 16));
                end else if (m_both) begin
                    exp_q.push_back({nar(in_q, m_shift, 8)[7:0], nar(in_i, m_shift, 8)[7:0]});
                end else if (m_part) begin
                    exp_q.push_back({nar(in_i, m_shift, 8)[7:0], m_part_b});
                    m_part = 0;
                end else begin
                    m_part_b = nar(in_i, m_shift, 8)[7:0];
                    m_part = 1;
                end
            end
            if (cfg_wr) begin
                if (good_cfg(cfg_data)) begin
                    m_pend = 1;
                    m_pend_val = cfg_data;
                end else begin
                    m_err = 1;
                end
            end
        end
    end

    task automatic write_cfg(input logic [31:0] v);
        @(posedge clk); #1;
        cfg_wr = 1'b1;
        cfg_data = v;
        @(posedge clk); #1;
        cfg_wr = 1'b0;
    endtask

    task automatic send(input logic [15:0] i, input logic [15:0] q);
        bit ok;
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_i = i;
        in_q = q;
        forever begin
            @(negedge clk);
            ok = in_ready;
            @(posedge clk); #1;
            if (ok) break;
        end
        in_valid = 1'b0;
    endtask

    task automatic drain();
        for (int k = 0; k < 400; k++) begin
            @(negedge clk);
            if (exp_q.size() == 0 && !out_valid) break;
        end
        check({cur_req, " drained"}, exp_q.size(), 0);
    endtask

    task automatic burst(input int n, input int seed);
        for (int k = 0; k < n; k++) begin
            send(16'(seed * 7919 + k * 4099), 16'(seed * 3571 - k * 6151));
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R1 out_valid", out_valid, 0);
        check("R1 cfg_err", cfg_err, 0);
        check("R1 bypass", bypass, 0);
        check("R1 in_ready", in_ready, 1);

        cur_req = "R1 default format R2";
        send(16'h8001, 16'h7FFE);
        send(16'h1234, 16'hFEDC);
        drain();

        cur_req = "R2 backpressure R9";
        backpress = 1'b1;
        burst(12, 3);
        drain();
        backpress = 1'b0;

        cur_req = "R3";
        write_cfg(32'h0000_0100);
        burst(6, 5);
        drain();

        cur_req = "R4";
        write_cfg(32'h0000_0288);
        send(16'h8000, 16'h7FFF);
        send(16'hFF00, 16'h0180);
        backpress = 1'b1;
        burst(10, 9);
        drain();
        backpress = 1'b0;

        cur_req = "R5";
        write_cfg(32'h0000_0088);
        send(16'h1200, 16'h0);
        send(16'hAB00, 16'h0);
        backpress = 1'b1;
        burst(10, 11);
        drain();
        backpress = 1'b0;

        cur_req = "R7";
        check("R7 err before", cfg_err, 0);
        write_cfg(32'h0000_0280);
        @(negedge clk);
        check("R7 err set", cfg_err, 1);
        check("R7 model err", cfg_err, m_err);
        write_cfg(32'h0000_0A88);
        write_cfg(32'h0000_0300);
        write_cfg(32'h0000_0088);
        @(negedge clk);
        check("R7 err sticky", cfg_err, 1);
        send(16'h5500, 16'h1111);
        send(16'h6600, 16'h2222);
        drain();
        write_cfg(32'h0010_0088);
        send(16'h7700, 16'h1111);
        send(16'h8800, 16'h2222);
        drain();

        cur_req = "R6";
        write_cfg(32'h0000_0688);
        repeat (3) @(negedge clk);
        check("R6 bypass", bypass, 1);
        send(16'h4321, 16'h8765);
        drain();
        write_cfg(32'h0000_0288);
        repeat (3) @(negedge clk);
        check("R6 bypass cleared", bypass, 0);

        cur_req = "R8";
        write_cfg(32'h0000_0088);
        send(16'hC300, 16'h0);
        write_cfg(32'h0000_0300);
        repeat (3) @(negedge clk);
        check("R8 half word held", out_valid, 0);
        send(16'h3C00, 16'h0);
        send(16'hBEEF, 16'hCAFE);
        drain();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule